// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit buffer descriptors kept in external memory and turns each ready descriptor into one buffer command for a downstream DMA engine. Software fills in a descriptor and then writes the transmit-demand strobe. The fetcher then reads the descriptor at its current ring position. A descriptor is two 32-bit memory words. The word at offset 0 carries the 16-bit status/control half in bits 31:16 and the 16-bit byte count in bits 15:0. The word at offset 4 is the 32-bit buffer address.

For each owned descriptor the block issues a command that carries the buffer address, the byte count, first/last-of-frame markers and a CRC mode. It waits for the command to be accepted. It then writes the status half back to offset 0 with the ready bit cleared, and it moves on to the next descriptor without a new demand. The ring closes through a per-descriptor wrap flag, which sends the walk back to the base address given on `ring_base`. A descriptor that is not yet owned parks the block until the next demand. A buffer address that is not 4-byte aligned halts the ring with a sticky error.

Status half bit map: bit 15 ready/owned, bit 13 wrap, bit 11 last buffer of frame, bit 10 append normal CRC, bit 9 append inverted CRC. Bit 12 belongs to software, and bits 8..0 are reserved.

Top module: `txr_ring_fetch`

## Requirements
- R1: After reset the block is idle: `mem_rd_req`, `mem_wr_req`, `cmd_valid` and `ring_err` are 0, and no read is made until `tx_demand` is pulsed. The first poll after reset reads `ring_base`.
- R2: A demand pulse while idle starts a poll. The block reads the status/length word at the current descriptor address and then, if the descriptor is owned, the pointer word at that address plus 4.
- R3: If status bit 15 is 0, the block issues no command and no write, and it returns to idle. Later polls happen only after another demand, and they start at the same descriptor address.
- R4: A demand that arrives while a poll or a buffer is in progress is remembered. This includes a demand in the very cycle a not-owned status word returns. The next not-owned descriptor is then read once more instead of the block going idle.
- R5: After a descriptor is finished, the next descriptor address is `ring_base` if status bit 13 was 1, and the current address plus 8 otherwise.
- R6: The command carries `cmd_addr` = the pointer word, `cmd_len` = the length field unchanged, and `cmd_last` = status bit 11. `cmd_first` is 1 for the first buffer after reset or after a buffer with bit 11 set, and 0 otherwise.
- R7: `cmd_crc` is 2'b00 (none) unless bit 11 is set. When bit 11 is set, it is 2'b10 (inverted CRC) if bit 9 is set, else 2'b01 (normal CRC) if bit 10 is set, else 2'b00.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command and all its fields hold steady.
- R9: Once a command is accepted, exactly one write is made, to the descriptor's offset 0. Its 16-bit data equals the status half as read with bit 15 cleared. The length and pointer words are never written.
- R10: Status bit 12 and bits 8..0 change neither the command fields nor the ring sequencing, and they are written back unchanged.
- R11: A pointer word with bits 1:0 not zero raises `ring_err`. No command or write-back follows, no further memory reads are made, and demands are ignored until reset.
- R12: After a write-back completes, the block polls the next descriptor on its own, without a demand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of the first descriptor of the ring |
| tx_demand | input | 1 | One-cycle strobe from the transmit-demand register write |
| mem_rd_req | output | 1 | Read request, held until `mem_rd_valid` |
| mem_rd_addr | output | 32 | Read byte address (descriptor + 0 or + 4) |
| mem_rd_valid | input | 1 | Read data valid, one cycle per request |
| mem_rd_data | input | 32 | Read data word |
| mem_wr_req | output | 1 | Status write-back request, held until `mem_wr_ack` |
| mem_wr_addr | output | 32 | Write byte address (descriptor + 0) |
| mem_wr_data | output | 16 | Status half to store |
| mem_wr_ack | input | 1 | Write accepted, one cycle per request |
| cmd_valid | output | 1 | Buffer command valid |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | 32 | Buffer byte address |
| cmd_len | output | 16 | Buffer byte count |
| cmd_first | output | 1 | First buffer of a frame |
| cmd_last | output | 1 | Last buffer of a frame |
| cmd_crc | output | 2 | CRC mode: 00 none, 01 normal, 10 inverted |
| ring_err | output | 1 | Sticky misaligned-buffer error |

## Verification
Two events can fall on the same clock edge: a new demand strobe, and the return of a status word whose ready bit is clear. If the demand were dropped, the block would go idle with freshly posted work unseen. The bench arms a hook in its memory model that raises `tx_demand` in exactly the cycle it returns the not-owned status. It then judges by the read log that the same descriptor address is read a second time and then the block idles. A related case raises the demand while a command is stalled by `cmd_ready`, and it expects the same single re-poll once the ring reaches a not-owned entry.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Status half bit positions; the downstream DMA and software both decode these.
    localparam int unsigned ST_READY  = 15;
    localparam int unsigned ST_WRAP   = 13;
    localparam int unsigned ST_LAST   = 11;
    localparam int unsigned ST_TXCRC  = 10;
    localparam int unsigned ST_BADCRC = 9;

    typedef enum logic [1:0] {
        CRC_NONE = 2'b00,
        CRC_GOOD = 2'b01,
        CRC_BAD  = 2'b10
    } crc_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_PTR,
        S_CMD,
        S_WB,
        S_ERR
    } fsm_e;

    typedef struct packed {
        logic      ready;
        logic      wrap;
        logic      last;
        crc_mode_e crc;
    } stat_flags_t;

endpackage

// File: rtl/txr_desc_decode.sv
module txr_desc_decode
    import txr_pkg::*;
(
    input  logic [15:0]  stat,
    output stat_flags_t  flags
);

    logic unused_sw_bits;
    assign unused_sw_bits = ^{stat[14], stat[12], stat[8:0]};

    always_comb begin
        flags.ready = stat[ST_READY];
        flags.wrap  = stat[ST_WRAP];
        flags.last  = stat[ST_LAST];
        if (!stat[ST_LAST]) begin
            flags.crc = CRC_NONE;
        end else if (stat[ST_BADCRC]) begin
            flags.crc = CRC_BAD;
        end else if (stat[ST_TXCRC]) begin
            flags.crc = CRC_GOOD;
        end else begin
            flags.crc = CRC_NONE;
        end
    end

endmodule

// File: rtl/txr_addr_seq.sv
module txr_addr_seq #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    typedef struct packed {
        logic              at_start;
        logic [ADDR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    assign cur_addr = seq_q.at_start ? ring_base : seq_q.ptr;

    always_comb begin
        seq_d = seq_q;
        if (advance) begin
            if (wrap) begin
                seq_d.at_start = 1'b1;
            end else begin
                seq_d.at_start = 1'b0;
                seq_d.ptr      = cur_addr + STEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.at_start <= 1'b1;
            seq_q.ptr      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R5: wrap returns to the ring base, otherwise step by one descriptor
    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        advance && wrap |=> cur_addr == ring_base);
    a_r5_step_next: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !wrap |=> cur_addr == $past(cur_addr) + STEP);
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !advance && !seq_q.at_start |=> seq_q.at_start || $stable(seq_q.ptr));

endmodule

// File: rtl/txr_frame_track.sv
module txr_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_done,
    input  logic buf_last,
    output logic first
);

    typedef struct packed {
        logic open;
    } frm_t;

    frm_t frm_d, frm_q;

    assign first = !frm_q.open;

    always_comb begin
        frm_d = frm_q;
        if (buf_done) begin
            frm_d.open = !buf_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q.open <= 1'b0;
        end else begin
            frm_q <= frm_d;
        end
    end

    // R6: a buffer closing a frame makes the next one a frame start
    a_r6_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done && buf_last |=> first);
    a_r6_not_first_mid: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done && !buf_last |=> !first);

endmodule

// File: rtl/txr_ring_fetch.sv
module txr_ring_fetch
    import txr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned DESC_BYTES = 8,
    parameter int unsigned PTR_OFS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              tx_demand,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [15:0]       mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_first,
    output logic              cmd_last,
    output logic [1:0]        cmd_crc,
    output logic              ring_err
);

    localparam int unsigned      STAT_LSB  = 16;
    localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(PTR_OFS);
    localparam logic [15:0]       READY_MASK = 16'(1) << ST_READY;

    typedef struct packed {
        fsm_e              state;
        logic [15:0]       stat;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] ptr;
        logic              pend;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              advance;
    logic              buf_done;
    logic              first;
    stat_flags_t       flags;
    logic              live_ready;
    logic              unused_rd_bits;

    assign live_ready = mem_rd_data[STAT_LSB + ST_READY];
    assign unused_rd_bits = ^mem_rd_data[15:LEN_W > 15 ? 15 : LEN_W];

    txr_desc_decode i_decode (
        .stat  (ctl_q.stat),
        .flags (flags)
    );

    txr_addr_seq #(
        .ADDR_W     (ADDR_W),
        .DESC_BYTES (DESC_BYTES)
    ) i_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .advance   (advance),
        .wrap      (flags.wrap),
        .cur_addr  (cur_addr)
    );

    txr_frame_track i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_done (buf_done),
        .buf_last (flags.last),
        .first    (first)
    );

    always_comb begin
        ctl_d       = ctl_q;
        mem_rd_req  = 1'b0;
        mem_rd_addr = cur_addr;
        mem_wr_req  = 1'b0;
        cmd_valid   = 1'b0;
        advance     = 1'b0;
        buf_done    = 1'b0;

        // Remember demands that land while work is under way.
        if (tx_demand && ctl_q.state != S_IDLE && ctl_q.state != S_ERR) begin
            ctl_d.pend = 1'b1;
        end

        unique case (ctl_q.state)
            S_IDLE: begin
                if (tx_demand) begin
                    ctl_d.state = S_RD_STAT;
                    ctl_d.pend  = 1'b0;
                end
            end
            S_RD_STAT: begin
                mem_rd_req = 1'b1;
                if (mem_rd_valid) begin
                    ctl_d.stat = mem_rd_data[STAT_LSB +: 16];
                    ctl_d.len  = mem_rd_data[LEN_W-1:0];
                    if (live_ready) begin
                        ctl_d.state = S_RD_PTR;
                    end else if (ctl_q.pend || tx_demand) begin
                        ctl_d.state = S_RD_STAT;
                        ctl_d.pend  = 1'b0;
                    end else begin
                        ctl_d.state = S_IDLE;
                        ctl_d.pend  = 1'b0;
                    end
                end
            end
            S_RD_PTR: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = cur_addr + PTR_STEP;
                if (mem_rd_valid) begin
                    ctl_d.ptr = mem_rd_data[ADDR_W-1:0];
                    if (mem_rd_data[1:0] != 2'b00) begin
                        ctl_d.state = S_ERR;
                        ctl_d.err   = 1'b1;
                        ctl_d.pend  = 1'b0;
                    end else begin
                        ctl_d.state = S_CMD;
                    end
                end
            end
            S_CMD: begin
                cmd_valid = 1'b1;
                if (cmd_ready) begin
                    buf_done    = 1'b1;
                    ctl_d.state = S_WB;
                end
            end
            S_WB: begin
                mem_wr_req = 1'b1;
                if (mem_wr_ack) begin
                    advance     = 1'b1;
                    ctl_d.state = S_RD_STAT;
                end
            end
            S_ERR: begin
                ctl_d.pend = 1'b0;
            end
            default: begin
                ctl_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= S_IDLE;
            ctl_q.stat  <= '0;
            ctl_q.len   <= '0;
            ctl_q.ptr   <= '0;
            ctl_q.pend  <= 1'b0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_wr_addr = cur_addr;
    assign mem_wr_data = ctl_q.stat & ~READY_MASK;
    assign cmd_addr    = ctl_q.ptr;
    assign cmd_len     = ctl_q.len;
    assign cmd_first   = first;
    assign cmd_last    = flags.last;
    assign cmd_crc     = flags.crc;
    assign ring_err    = ctl_q.err;

    // R8: an offered command stays put until taken
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
            && $stable(cmd_first) && $stable(cmd_last) && $stable(cmd_crc));
    // R9: write-back never hands ownership back to software with ready set
    a_r9_wb_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> !mem_wr_data[ST_READY]);
    // R9: a write-back only starts right after a command was accepted
    a_r9_wb_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(cmd_valid && cmd_ready));
    // R7: CRC mode only on the last buffer of a frame
    a_r7_crc_last_only: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_last |-> cmd_crc == CRC_NONE);
    // R11: commands only ever carry aligned buffers
    a_r11_cmd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_addr[1:0] == 2'b00);
    // R11: the error is sticky and silences every port
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ring_err |=> ring_err);
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ring_err |-> !mem_rd_req && !mem_wr_req && !cmd_valid);
    // R1: only one kind of request at a time
    a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd_req, mem_wr_req, cmd_valid}) <= 1);

endmodule

// File: tb/test_txr_ring_fetch.sv
module test_txr_ring_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        demand_task = 1'b0;
    logic        demand_hook = 1'b0;
    logic        tx_demand;
    logic        mem_rd_req, mem_wr_req, cmd_valid, cmd_first, cmd_last, ring_err;
    logic [31:0] mem_rd_addr, mem_wr_addr, cmd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [15:0] mem_wr_data, cmd_len;
    logic        mem_wr_ack = 1'b0;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_crc;

    assign tx_demand = demand_task | demand_hook;

    always #5 clk = ~clk;

    txr_ring_fetch i_txr_ring_fetch (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_demand(tx_demand),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_crc(cmd_crc), .ring_err(ring_err)
    );

    logic [31:0] mem [0:255];
    logic [31:0] rlog [0:63];
    logic [31:0] wlog_addr [0:15];
    logic [15:0] wlog_data [0:15];
    logic [31:0] clog_addr [0:15];
    logic [15:0] clog_len [0:15];
    logic [3:0]  clog_flags [0:15];
    int rcnt = 0, wcnt = 0, ccnt = 0;
    int r0 = 0, w0 = 0, c0 = 0;
    int stall = 0, stall_cnt = 0;
    logic        hook_arm = 1'b0;
    logic [31:0] hook_addr = '0;
    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic service();
        forever begin
            @(negedge clk);
            demand_hook = 1'b0;
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            else if (mem_rd_req) begin
                mem_rd_data  = mem[mem_rd_addr[9:2]];
                mem_rd_valid = 1'b1;
                if (rcnt < 64) rlog[rcnt] = mem_rd_addr;
                rcnt++;
                if (hook_arm && mem_rd_addr == hook_addr) begin
                    demand_hook = 1'b1;
                    hook_arm    = 1'b0;
                end
            end
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_wr_req) begin
                mem_wr_ack = 1'b1;
                mem[mem_wr_addr[9:2]][31:16] = mem_wr_data;
                if (wcnt < 16) begin
                    wlog_addr[wcnt] = mem_wr_addr;
                    wlog_data[wcnt] = mem_wr_data;
                end
                wcnt++;
            end
            if (cmd_ready) cmd_ready = 1'b0;
            else if (cmd_valid) begin
                if (stall_cnt >= stall) begin
                    cmd_ready = 1'b1;
                    stall_cnt = 0;
                    if (ccnt < 16) begin
                        clog_addr[ccnt]  = cmd_addr;
                        clog_len[ccnt]   = cmd_len;
                        clog_flags[ccnt] = {cmd_first, cmd_last, cmd_crc};
                    end
                    ccnt++;
                end else stall_cnt++;
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic watchdog();
        repeat (100000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    endtask

    task automatic mark();
        r0 = rcnt; w0 = wcnt; c0 = ccnt;
    endtask

    task automatic pulse_demand();
        @(negedge clk);
        demand_task = 1'b1;
        @(negedge clk);
        demand_task = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [15:0] st,
                            input logic [15:0] len, input logic [31:0] ptr);
        mem[a[9:2]]     = {st, len};
        mem[a[9:2] + 1] = ptr;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic t_reset();
        apply_reset();
        check(!mem_rd_req && !mem_wr_req && !cmd_valid, "R1 idle after reset",
              {29'd0, mem_rd_req, mem_wr_req, cmd_valid}, 0);
        check(!ring_err, "R1 error clear", {31'd0, ring_err}, 0);
        mark();
        settle(10);
        check(rcnt == r0, "R1 no read without demand", rcnt - r0, 0);
    endtask

    task automatic t_single();
        put_desc(32'h100, 16'h8C00, 16'd60, 32'h2000);
        mark();
        pulse_demand();
        settle(40);
        check(rcnt - r0 == 3, "R2 read count", rcnt - r0, 3);
        check(rlog[r0] == 32'h100, "R1 first poll at ring_base", rlog[r0], 32'h100);
        check(rlog[r0+1] == 32'h104, "R2 pointer word read", rlog[r0+1], 32'h104);
        check(rlog[r0+2] == 32'h108, "R12 next polled without demand", rlog[r0+2], 32'h108);
        check(ccnt - c0 == 1, "R6 one command", ccnt - c0, 1);
        check(clog_addr[c0] == 32'h2000, "R6 cmd_addr", clog_addr[c0], 32'h2000);
        check(clog_len[c0] == 16'd60, "R6 cmd_len", {16'd0, clog_len[c0]}, 60);
        check(clog_flags[c0] == 4'b1101, "R7 single buffer normal CRC",
              {28'd0, clog_flags[c0]}, 4'b1101);
        check(wcnt - w0 == 1 && wlog_addr[w0] == 32'h100, "R9 write-back address",
              wlog_addr[w0], 32'h100);
        check(mem[8'h40] == {16'h0C00, 16'd60}, "R9 ready cleared, length kept",
              mem[8'h40], {16'h0C00, 16'd60});
    endtask

    task automatic t_multi_wrap();
        put_desc(32'h108, 16'h95FF, 16'd100, 32'h2100);
        put_desc(32'h110, 16'hAE00, 16'd14, 32'h2200);
        stall = 2;
        mark();
        pulse_demand();
        settle(80);
        stall = 0;
        check(ccnt - c0 == 2, "R6 two buffers", ccnt - c0, 2);
        check(clog_addr[c0] == 32'h2100 && clog_len[c0] == 16'd100,
              "R10 sw/reserved bits leave fields alone", clog_addr[c0], 32'h2100);
        check(clog_flags[c0] == 4'b1000, "R7 no CRC on non-last (first=1,last=0)",
              {28'd0, clog_flags[c0]}, 4'b1000);
        check(clog_flags[c0+1] == 4'b0110, "R7 inverted CRC wins (first=0,last=1)",
              {28'd0, clog_flags[c0+1]}, 4'b0110);
        check(wlog_data[w0] == 16'h15FF, "R10 bit12 and reserved written back",
              {16'd0, wlog_data[w0]}, 16'h15FF);
        check(wlog_data[w0+1] == 16'h2E00, "R9 second write-back",
              {16'd0, wlog_data[w0+1]}, 16'h2E00);
        check(rcnt - r0 == 5, "R5 read count", rcnt - r0, 5);
        check(rlog[r0+2] == 32'h110, "R5 consecutive step", rlog[r0+2], 32'h110);
        check(rlog[r0+4] == 32'h100, "R5 wrap to ring_base", rlog[r0+4], 32'h100);
    endtask

    task automatic t_not_ready();
        mark();
        pulse_demand();
        settle(20);
        check(rcnt - r0 == 1 && rlog[r0] == 32'h100, "R3 lone poll of not-owned",
              rlog[r0], 32'h100);
        check(ccnt == c0 && wcnt == w0, "R3 no command or write", ccnt - c0, 0);
        put_desc(32'h100, 16'h8800, 16'd1, 32'h3000);
        mark();
        settle(20);
        check(rcnt == r0, "R3 no poll without demand", rcnt - r0, 0);
        pulse_demand();
        settle(40);
        check(rlog[r0] == 32'h100, "R3 same address re-polled", rlog[r0], 32'h100);
        check(ccnt - c0 == 1 && clog_flags[c0] == 4'b1100, "R7 last without CRC",
              {28'd0, clog_flags[c0]}, 4'b1100);
    endtask

    task automatic t_demand_busy();
        put_desc(32'h108, 16'h8800, 16'd7, 32'h5000);
        stall = 6;
        mark();
        pulse_demand();
        do @(negedge clk); while (!cmd_valid);
        pulse_demand();
        settle(60);
        stall = 0;
        check(rcnt - r0 == 4, "R4 one extra poll after busy demand", rcnt - r0, 4);
        check(rlog[r0+3] == 32'h110, "R4 re-poll address", rlog[r0+3], 32'h110);
    endtask

    task automatic t_demand_same_cycle();
        hook_addr = 32'h110;
        hook_arm  = 1'b1;
        mark();
        pulse_demand();
        settle(30);
        check(rcnt - r0 == 2, "R4 same-cycle demand re-polls once", rcnt - r0, 2);
        check(rlog[r0+1] == 32'h110, "R4 re-poll same descriptor", rlog[r0+1], 32'h110);
    endtask

    task automatic t_misaligned();
        put_desc(32'h110, 16'h8800, 16'd8, 32'h4002);
        mark();
        pulse_demand();
        settle(30);
        check(ring_err, "R11 error raised", {31'd0, ring_err}, 1);
        check(ccnt == c0 && wcnt == w0, "R11 no command or write", wcnt - w0, 0);
        check(mem[8'h44][31:16] == 16'h8800, "R11 status untouched",
              {16'd0, mem[8'h44][31:16]}, 16'h8800);
        mark();
        pulse_demand();
        settle(20);
        check(rcnt == r0 && ring_err, "R11 demand ignored", rcnt - r0, 0);
        apply_reset();
        check(!ring_err, "R1 reset clears error", {31'd0, ring_err}, 0);
        mark();
        pulse_demand();
        settle(20);
        check(rcnt - r0 == 1 && rlog[r0] == 32'h100, "R1 pointer back at ring_base",
              rlog[r0], 32'h100);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        fork
            service();
            watchdog();
        join_none
        t_reset();
        t_single();
        t_multi_wrap();
        t_not_ready();
        t_demand_busy();
        t_demand_same_cycle();
        t_misaligned();
        summary();
        $finish;
    end

endmodule